// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged L1 Tag Lookup

This block holds the tags of a level-one data cache and answers whether a load or store hits. The cache has 64 sets of 8 ways each, with 64-byte lines. Six bits pick the byte within a line, and six bits pick the set. Together these twelve bits are the page offset. Translation never changes them, so the set can be chosen from the virtual address while the translation lookaside structure is still busy. The tag of each line is the full 40-bit physical page number.

A lookup takes two cycles. In the request cycle the requester presents the set-selecting virtual address bits. At the edge that ends that cycle, the tags and valid bits of all eight ways of that set are captured. In the following cycle the requester presents the translated page number and a translation-valid flag. The block then compares the page number against the captured tags and reports hit with the way, or miss. If translation is not ready in that cycle, the block reports neither, and the requester replays the access.

A refill port installs a tag into the tree pseudo-LRU victim of a chosen set. A single invalidate input drops every line at once.

Top module: `vipt_tag_lookup`

## Requirements
- R1: After reset every line is invalid, so every lookup with a valid translation reports miss, and hit and miss are both low while no lookup is in flight.
- R2: The set of a lookup is taken from `req_va_idx`, which carries virtual address bits 11 down to 6. Set number s reads exactly the lines installed with `fill_set` equal to s.
- R3: A request accepted at the clock edge that ends the request cycle is answered combinationally in the next cycle from `xlat_ppn` and `xlat_valid`. When a valid way of the set holds a tag equal to `xlat_ppn`, `hit` is 1 and `hit_way` gives that way number (0 to 7).
- R4: When `xlat_valid` is 1 in the answer cycle and no valid way of the set matches, `miss` is 1 and `hit` is 0.
- R5: When `xlat_valid` is 0 in the answer cycle, both `hit` and `miss` are 0 even if a way matches, and the replacement state is left unchanged.
- R6: `hit` and `miss` are never 1 together, and neither is 1 in a cycle that does not follow an accepted request.
- R7: A refill (`fill_valid` = 1) writes `fill_ppn` into the victim way of `fill_set` and marks that way valid from the next edge on.
- R8: Each set keeps a 7-bit tree, with node k (1 to 7) at bit k-1 and node children 2k and 2k+1. The victim is found by walking from node 1: a bit of 0 leads to the lower-numbered half. An access sets every node bit on its path to point away from the accessed way. All trees are zero after reset, so eight refills into one set, with no hits between them, land in ways 0, 4, 2, 6, 1, 5, 3, 7.
- R9: `inval_all` clears every valid bit at the next edge. A refill presented in the same cycle is dropped, and the trees are not changed.
- R10: A refill or an `inval_all` presented in the request cycle is already seen by that lookup.
- R11: A hit counts as an access of its way in its set's tree, so the next victim of that set avoids it.
- R12: When several valid ways hold the matching tag, `hit_way` reports the lowest-numbered one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Start a lookup this cycle |
| req_va_idx | input | 6 | Virtual address bits 11:6 (set select) |
| xlat_valid | input | 1 | Translation result present in the answer cycle |
| xlat_ppn | input | 40 | Translated physical page number |
| fill_valid | input | 1 | Install a tag this cycle |
| fill_set | input | 6 | Set receiving the refill |
| fill_ppn | input | 40 | Tag written by the refill |
| inval_all | input | 1 | Drop every line |
| hit | output | 1 | Lookup matched a valid way |
| hit_way | output | 3 | Matching way when hit is 1 |
| miss | output | 1 | Lookup found no valid match |

## Verification
The hardest case to reach from the ports is a refill or invalidate that lands on the very edge where a lookup captures its set. The bench provokes it by raising `req_valid` and `fill_valid` (or `inval_all`) in the same cycle for the same set, then offering the new tag in the answer cycle. The replacement walk is also hard to see, because the tree is never visible. The bench therefore fills all 512 lines, checks the first set's placement against the fixed order, and repeatedly hits a way before refilling. A reference tree kept in the bench predicts each landing way, and that prediction is confirmed through `hit_way`.

// File: rtl/vipt_pkg.sv
// Package: default geometry of the VIPT tag lookup and the lookup outcome type.
// Assumes: power-of-two sets and ways, sets*line bytes equal to the page size.
package vipt_pkg;
    localparam int unsigned VIPT_SETS       = 64;
    localparam int unsigned VIPT_WAYS       = 8;
    localparam int unsigned VIPT_LINE_BYTES = 64;
    localparam int unsigned VIPT_PPN_W      = 40;

    typedef enum logic [1:0] {
        OUT_IDLE   = 2'd0,
        OUT_HIT    = 2'd1,
        OUT_MISS   = 2'd2,
        OUT_REPLAY = 2'd3
    } lookup_outcome_e;
endpackage

// File: rtl/vipt_tag_store.sv
// Tag and valid storage for all sets plus the stage-one read register.
// Does: captures all ways of the requested set at the request edge, with a
//       same-edge refill or clear forwarded into the captured copy.
// Assumes: clr_all outranks wr_en; tags need no reset (valid bits guard them).
module vipt_tag_store #(
    parameter  int unsigned SETS  = 64,
    parameter  int unsigned WAYS  = 8,
    parameter  int unsigned PPN_W = 40,
    localparam int unsigned IDX_W = $clog2(SETS),
    localparam int unsigned WAY_W = $clog2(WAYS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rd_en,
    input  logic [IDX_W-1:0]            rd_set,
    output logic [WAYS-1:0][PPN_W-1:0]  rd_tags,
    output logic [WAYS-1:0]             rd_valid,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_set,
    input  logic [WAY_W-1:0]            wr_way,
    input  logic [PPN_W-1:0]            wr_tag,
    input  logic                        clr_all
);
    logic [PPN_W-1:0] tag_q   [SETS][WAYS];
    logic [WAYS-1:0]  valid_q [SETS];
    logic [WAYS-1:0]  wr_onehot;
    logic             wr_live;
    logic             fwd_set;

    assign wr_live = wr_en && !clr_all;
    assign fwd_set = wr_live && (wr_set == rd_set);

    // Decode the written way into a one-hot mask.
    always_comb begin
        wr_onehot         = '0;
        wr_onehot[wr_way] = 1'b1;
    end

    // Valid bits: cleared by reset or clear-all, set by a refill.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) begin
            for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
        end else if (wr_live) begin
            valid_q[wr_set] <= valid_q[wr_set] | wr_onehot;
        end
    end

    // Tag array write.
    always_ff @(posedge clk) begin
        if (wr_live) tag_q[wr_set][wr_way] <= wr_tag;
    end

    // Stage-one capture of the valid bits of the requested set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= '0;
        end else if (rd_en) begin
            if (clr_all) rd_valid <= '0;
            else         rd_valid <= valid_q[rd_set] | (fwd_set ? wr_onehot : '0);
        end
    end

    // Stage-one capture of all tags of the requested set.
    always_ff @(posedge clk) begin
        if (rd_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (fwd_set && (wr_way == WAY_W'(w))) rd_tags[w] <= wr_tag;
                else                                  rd_tags[w] <= tag_q[rd_set][w];
            end
        end
    end
endmodule

// File: rtl/vipt_plru.sv
// Tree pseudo-LRU state, one tree of WAYS-1 bits per set.
// Does: names the victim of the refill set and records hits and refills.
// Assumes: WAYS is a power of two >= 2; node k lives at bit k-1, a 0 bit
//          steers the victim to the lower half. A hit and a refill of the
//          same set in one cycle: the victim is taken after the hit update.
module vipt_plru #(
    parameter  int unsigned SETS  = 64,
    parameter  int unsigned WAYS  = 8,
    localparam int unsigned IDX_W = $clog2(SETS),
    localparam int unsigned WAY_W = $clog2(WAYS),
    localparam int unsigned NB    = WAYS - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_en,
    input  logic [IDX_W-1:0] hit_set,
    input  logic [WAY_W-1:0] hit_way,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_set,
    output logic [WAY_W-1:0] victim_way
);
    logic [NB-1:0] tree_q [SETS];
    logic [NB-1:0] after_hit;
    logic [NB-1:0] fill_base;
    logic [NB-1:0] after_fill;

    // Point every node on the path of 'way' away from it.
    function automatic logic [NB-1:0] point_away(input logic [NB-1:0] t,
                                                 input logic [WAY_W-1:0] way);
        logic [NB-1:0] r;
        int            node;
        r    = t;
        node = 1;
        for (int lvl = 0; lvl < WAY_W; lvl++) begin
            r[node-1] = ~way[WAY_W-1-lvl];
            node      = 2 * node + int'(way[WAY_W-1-lvl]);
        end
        return r;
    endfunction

    // Follow the tree bits from the root to a leaf.
    function automatic logic [WAY_W-1:0] walk(input logic [NB-1:0] t);
        int node;
        node = 1;
        for (int lvl = 0; lvl < WAY_W; lvl++) node = 2 * node + int'(t[node-1]);
        return WAY_W'(node - int'(WAYS));
    endfunction

    // Next-state trees for the hit set and the refill set.
    always_comb begin
        after_hit  = point_away(tree_q[hit_set], hit_way);
        fill_base  = (hit_en && (hit_set == fill_set)) ? after_hit : tree_q[fill_set];
        victim_way = walk(fill_base);
        after_fill = point_away(fill_base, victim_way);
    end

    // Tree state update; a refill of the hit set already includes the hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
        end else begin
            if (hit_en)  tree_q[hit_set]  <= after_hit;
            if (fill_en) tree_q[fill_set] <= after_fill;
        end
    end
endmodule

// File: rtl/vipt_tag_compare.sv
// Stage-two compare of the captured ways against the translated page number.
// Does: reports hit with the lowest matching way, miss, or nothing (replay).
// Assumes: lk_valid marks a lookup captured at the previous edge.
module vipt_tag_compare #(
    parameter  int unsigned WAYS  = 8,
    parameter  int unsigned PPN_W = 40,
    localparam int unsigned WAY_W = $clog2(WAYS)
) (
    input  logic                       lk_valid,
    input  logic                       xlat_valid,
    input  logic [PPN_W-1:0]           ppn,
    input  logic [WAYS-1:0][PPN_W-1:0] tags,
    input  logic [WAYS-1:0]            valids,
    output logic                       hit,
    output logic [WAY_W-1:0]           hit_way,
    output logic                       miss
);
    import vipt_pkg::*;

    logic [WAYS-1:0] match;
    lookup_outcome_e outcome;

    // Per-way tag comparison.
    always_comb begin
        for (int w = 0; w < WAYS; w++) match[w] = valids[w] && (tags[w] == ppn);
    end

    // Lowest matching way wins.
    always_comb begin
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) hit_way = WAY_W'(w);
        end
    end

    // Classify the lookup.
    always_comb begin
        if (!lk_valid)        outcome = OUT_IDLE;
        else if (!xlat_valid) outcome = OUT_REPLAY;
        else if (|match)      outcome = OUT_HIT;
        else                  outcome = OUT_MISS;
    end

    assign hit  = (outcome == OUT_HIT);
    assign miss = (outcome == OUT_MISS);
endmodule

// File: rtl/vipt_tag_lookup.sv
// Top of the VIPT tag lookup: two-stage lookup, refill port, clear-all.
// Does: stage one captures the set selected by virtual bits above the line
//       offset; stage two compares against the page number from translation.
// Assumes: SETS*LINE_BYTES spans exactly the untranslated page offset.
module vipt_tag_lookup #(
    parameter  int unsigned SETS       = vipt_pkg::VIPT_SETS,
    parameter  int unsigned WAYS       = vipt_pkg::VIPT_WAYS,
    parameter  int unsigned LINE_BYTES = vipt_pkg::VIPT_LINE_BYTES,
    parameter  int unsigned PPN_W      = vipt_pkg::VIPT_PPN_W,
    localparam int unsigned OFS_W      = $clog2(LINE_BYTES),
    localparam int unsigned IDX_W      = $clog2(SETS),
    localparam int unsigned PGOFS_W    = OFS_W + IDX_W,
    localparam int unsigned WAY_W      = $clog2(WAYS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [PGOFS_W-1:OFS_W]   req_va_idx,
    input  logic                     xlat_valid,
    input  logic [PPN_W-1:0]         xlat_ppn,
    input  logic                     fill_valid,
    input  logic [IDX_W-1:0]         fill_set,
    input  logic [PPN_W-1:0]         fill_ppn,
    input  logic                     inval_all,
    output logic                     hit,
    output logic [WAY_W-1:0]         hit_way,
    output logic                     miss
);
    logic                       s2_valid;
    logic [IDX_W-1:0]           s2_set;
    logic [WAYS-1:0][PPN_W-1:0] s2_tags;
    logic [WAYS-1:0]            s2_valids;
    logic [WAY_W-1:0]           victim;
    logic                       fill_live;

    assign fill_live = fill_valid && !inval_all;

    // Stage-two bookkeeping: which set is being compared.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_valid <= 1'b0;
            s2_set   <= '0;
        end else begin
            s2_valid <= req_valid;
            if (req_valid) s2_set <= req_va_idx;
        end
    end

    vipt_tag_store #(.SETS(SETS), .WAYS(WAYS), .PPN_W(PPN_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (req_valid),
        .rd_set   (req_va_idx),
        .rd_tags  (s2_tags),
        .rd_valid (s2_valids),
        .wr_en    (fill_live),
        .wr_set   (fill_set),
        .wr_way   (victim),
        .wr_tag   (fill_ppn),
        .clr_all  (inval_all)
    );

    vipt_plru #(.SETS(SETS), .WAYS(WAYS)) u_plru (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_en     (hit),
        .hit_set    (s2_set),
        .hit_way    (hit_way),
        .fill_en    (fill_live),
        .fill_set   (fill_set),
        .victim_way (victim)
    );

    vipt_tag_compare #(.WAYS(WAYS), .PPN_W(PPN_W)) u_cmp (
        .lk_valid   (s2_valid),
        .xlat_valid (xlat_valid),
        .ppn        (xlat_ppn),
        .tags       (s2_tags),
        .valids     (s2_valids),
        .hit        (hit),
        .hit_way    (hit_way),
        .miss       (miss)
    );
endmodule

// File: rtl/vipt_tag_lookup_chk.sv
// Checker for the VIPT tag lookup, attached to every instance by bind.
// Watches only the port-level request/answer relationship.
module vipt_tag_lookup_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic xlat_valid,
    input logic inval_all,
    input logic hit,
    input logic miss
);
    // R6: never both outcomes at once
    a_r6_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit && miss));

    // R6: an outcome only follows an accepted request
    a_r6_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        (hit || miss) |-> $past(req_valid));

    // R5: missing translation gives no outcome
    a_r5_replay_silent: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (!xlat_valid -> (!hit && !miss)));

    // R4: present translation always gives an outcome
    a_r4_answer_given: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (xlat_valid -> (hit || miss)));

    // R10: clear-all in the request cycle is seen by that lookup
    a_r10_clear_seen: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && inval_all) |=> !hit);
endmodule

bind vipt_tag_lookup vipt_tag_lookup_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .xlat_valid (xlat_valid),
    .inval_all  (inval_all),
    .hit        (hit),
    .miss       (miss)
);

// File: tb/vipt_tag_lookup_test.sv
// Bench: sweeps every line of the default geometry against a reference model.
module vipt_tag_lookup_test;
    localparam int SETS  = 64;
    localparam int WAYS  = 8;
    localparam int PPN_W = 40;
    localparam int IDX_W = 6;
    localparam int WAY_W = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [11:6]      req_va_idx = '0;
    logic             xlat_valid = 1'b0;
    logic [PPN_W-1:0] xlat_ppn = '0;
    logic             fill_valid = 1'b0;
    logic [IDX_W-1:0] fill_set = '0;
    logic [PPN_W-1:0] fill_ppn = '0;
    logic             inval_all = 1'b0;
    logic             hit;
    logic [WAY_W-1:0] hit_way;
    logic             miss;

    always #5 clk = ~clk;

    vipt_tag_lookup uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va_idx(req_va_idx),
        .xlat_valid(xlat_valid), .xlat_ppn(xlat_ppn), .fill_valid(fill_valid),
        .fill_set(fill_set), .fill_ppn(fill_ppn), .inval_all(inval_all),
        .hit(hit), .hit_way(hit_way), .miss(miss)
    );

    // Reference state.
    logic [PPN_W-1:0] m_tag  [SETS][WAYS];
    logic             m_val  [SETS][WAYS];
    logic [WAYS-2:0]  m_tree [SETS];
    int checks = 0;
    int fails  = 0;
    int last_victim;

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int m_victim(int s);
        int node = 1;
        for (int l = 0; l < WAY_W; l++) node = 2 * node + int'(m_tree[s][node-1]);
        return node - WAYS;
    endfunction

    function automatic void m_touch(int s, int w);
        int node = 1;
        for (int l = 0; l < WAY_W; l++) begin
            int d = (w >> (WAY_W - 1 - l)) & 1;
            m_tree[s][node-1] = (d == 0);
            node = 2 * node + d;
        end
    endfunction

    function automatic void m_fill(int s, logic [PPN_W-1:0] p);
        int w = m_victim(s);
        m_tag[s][w] = p;
        m_val[s][w] = 1'b1;
        m_touch(s, w);
        last_victim = w;
    endfunction

    function automatic void m_clear();
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) m_val[s][w] = 1'b0;
    endfunction

    // Judge an answer cycle (called after inputs settle).
    task automatic judge(string req, int s, logic [PPN_W-1:0] p, bit xv);
        bit e_hit = 0;
        int e_way = 0;
        for (int w = WAYS - 1; w >= 0; w--)
            if (m_val[s][w] && m_tag[s][w] == p) begin e_hit = 1; e_way = w; end
        if (!xv) e_hit = 0;
        chk(req, {61'd0, hit, miss, 1'b0} | {61'd0, 2'b00, 1'b0},
            {61'd0, e_hit, xv && !e_hit, 1'b0});
        if (e_hit) chk(req, 64'(hit_way), 64'(e_way));
        chk("R6", 64'(hit && miss), 64'd0);
        if (e_hit) m_touch(s, e_way);
    endtask

    task automatic lookup(string req, int s, logic [PPN_W-1:0] p, bit xv);
        @(negedge clk);
        xlat_valid = 1'b0;
        req_valid  = 1'b1;
        req_va_idx = 6'(s);
        @(negedge clk);
        req_valid  = 1'b0;
        xlat_valid = xv;
        xlat_ppn   = p;
        #1;
        judge(req, s, p, xv);
    endtask

    task automatic fill(int s, logic [PPN_W-1:0] p);
        @(negedge clk);
        xlat_valid = 1'b0;
        fill_valid = 1'b1;
        fill_set   = 6'(s);
        fill_ppn   = p;
        m_fill(s, p);
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic clear_all(bit with_fill, int s, logic [PPN_W-1:0] p);
        @(negedge clk);
        xlat_valid = 1'b0;
        inval_all  = 1'b1;
        fill_valid = with_fill;
        fill_set   = 6'(s);
        fill_ppn   = p;
        m_clear();
        @(negedge clk);
        inval_all  = 1'b0;
        fill_valid = 1'b0;
    endtask

    function automatic logic [PPN_W-1:0] mk(int s, int k);
        return (40'(s) << 24) | (40'(k) << 12) | 40'h5A3 ^ (40'(s * 7 + k) << 32);
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        int order [8] = '{0, 4, 2, 6, 1, 5, 3, 7};
        for (int s = 0; s < SETS; s++) begin
            m_tree[s] = '0;
            for (int w = 0; w < WAYS; w++) begin m_val[s][w] = 1'b0; m_tag[s][w] = '0; end
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: idle outputs after reset
        chk("R1", {62'd0, hit, miss}, 64'd0);
        // R1: every set empty
        for (int s = 0; s < SETS; s++) lookup("R1", s, mk(s, 0), 1'b1);

        // R7: fill every line; R8: fixed landing order in a fresh set
        for (int s = 0; s < SETS; s++)
            for (int k = 0; k < WAYS; k++) fill(s, mk(s, k));
        for (int k = 0; k < WAYS; k++) begin
            lookup("R8", 0, mk(0, k), 1'b1);
            chk("R8", 64'(hit_way), 64'(order[k]));
        end
        // R2 R3: every other line found in its own set
        for (int s = 1; s < SETS; s++)
            for (int k = 0; k < WAYS; k++) lookup("R3", s, mk(s, (k * 3) % WAYS), 1'b1);
        // R4: tag of a neighbouring set misses
        for (int s = 0; s < SETS; s++) lookup("R4", s, mk((s + 1) % SETS, 2), 1'b1);
        // R5: no translation, no outcome, tree untouched (confirmed below)
        for (int s = 0; s < 8; s++) lookup("R5", s, mk(s, 1), 1'b0);
        // R11 R7: hit a way, then refill and find the replacement
        for (int i = 0; i < 16; i++) begin
            lookup("R11", 9, mk(9, i % WAYS), 1'b1);
            fill(9, mk(40 + i, 99));
            lookup("R7", 9, mk(40 + i, 99), 1'b1);
            chk("R11", 64'(hit_way), 64'(last_victim));
        end
        for (int k = 0; k < WAYS; k++) lookup("R7", 9, mk(9, k), 1'b1);
        // R9: clear everything
        clear_all(1'b0, 0, '0);
        for (int s = 0; s < SETS; s += 7) lookup("R9", s, mk(s, s % WAYS), 1'b1);
        // R9: refill together with clear is dropped
        clear_all(1'b1, 3, mk(3, 77));
        lookup("R9", 3, mk(3, 77), 1'b1);
        // R10: refill in the request cycle is seen
        @(negedge clk);
        req_valid = 1'b1; req_va_idx = 6'd12;
        fill_valid = 1'b1; fill_set = 6'd12; fill_ppn = mk(12, 50);
        m_fill(12, mk(12, 50));
        @(negedge clk);
        req_valid = 1'b0; fill_valid = 1'b0;
        xlat_valid = 1'b1; xlat_ppn = mk(12, 50);
        #1;
        judge("R10", 12, mk(12, 50), 1'b1);
        chk("R10", 64'(hit), 64'd1);
        // R10: clear in the request cycle is seen
        @(negedge clk);
        xlat_valid = 1'b0;
        req_valid = 1'b1; req_va_idx = 6'd12; inval_all = 1'b1;
        m_clear();
        @(negedge clk);
        req_valid = 1'b0; inval_all = 1'b0;
        xlat_valid = 1'b1; xlat_ppn = mk(12, 50);
        #1;
        judge("R10", 12, mk(12, 50), 1'b1);
        // R12: duplicate tag reports the lower way
        fill(20, mk(20, 5));
        fill(20, mk(20, 6));
        fill(20, mk(20, 5));
        lookup("R12", 20, mk(20, 5), 1'b1);
        @(negedge clk);
        xlat_valid = 1'b0;
        #1;
        chk("R6", {62'd0, hit, miss}, 64'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule